// File: doc/BRIEF.md
# Synchronizable PWM Timer Channel

This block is one channel of a free-running pulse-width timer. A counter runs from zero up to one less than a programmed period value and then starts again. A compare value splits each repeat into an active part and an inactive part, and a polarity bit chooses which output level counts as active. Software sets up the channel through a small write port that holds the period, the compare value, a phase value and a control word.

Several identical channels can share one time base. One channel acts as master and sends out a pulse at the end of each of its repeats. Each slave channel takes that pulse on its sync input and loads the phase value into its counter. A slave can pass the pulse on to the next channel or block it. If the slave periods divide the master period exactly, every channel restarts on the same edge, and the channel frequencies cannot beat against each other.

Top module: `sync_pwm_timer`

## Requirements
- R1: While reset is held, and after reset ends, the counter is 0 and all configuration is 0: period 0, compare 0, phase 0, stopped, active-high, sync input ignored, sync output in terminal-pulse mode. With this configuration the PWM output and the sync output stay low.
- R2: A write with `wr_en` high stores `wr_data` at the next clock edge, and the new value is used from the following cycle. The address selects the target: 0 period, 1 compare, 2 phase, 3 control. The control word bits are: bit 0 run, bit 1 invert polarity, bit 2 sync-input enable, bits 4:3 sync-output select.
- R3: While running with period P (P ≥ 2), the counter steps 0, 1, … P-1 and then returns to 0. This gives one repeat every P clocks, so periods 10 and 5 differ in frequency by exactly 2x. With P of 0 or 1 the counter stays at 0.
- R4: The channel is active while the counter is below the compare value. A compare of 0 keeps the output inactive all the time. A compare at or above the period keeps it active all the time.
- R5: With invert at 0 the active level is high. With invert at 1 the output is the complement.
- R6: With run at 0 the counter holds its value, so the PWM output does not change.
- R7: When sync-input enable is 1, a high `sync_in` loads the phase value into the counter at the next edge. This load takes priority over stepping and wrapping, and it also happens while the channel is stopped.
- R8: When sync-input enable is 0, `sync_in` has no effect on the counter.
- R9: Sync-output select 1 drives `sync_in` straight onto `sync_out` in the same cycle. Selects 2 and 3 hold `sync_out` low.
- R10: Sync-output select 0 drives `sync_out` high for exactly the cycle in which a running counter holds P-1. For P ≥ 2 this is a one-cycle pulse every P clocks, and no pulse comes while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Phase-load pulse from the previous channel |
| sync_out | output | 1 | Sync pulse to the next channel |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that `sync_in` and the write port change only between clock edges and are never unknown after reset. The single-pulse property also assumes that no register write and no phase load happens in the cycle the pulse appears. The bench changes all inputs on the falling edge and keeps them at defined values from time zero. It runs the single-pulse stretches with the write strobe low and no sync input. Phase loads and writes are placed only in windows where the property does not apply.

// File: rtl/sync_pwm_pkg.sv
// Shared definitions for the synchronizable PWM timer channel.
// Assumes the data width of the write port is at least 5 bits.
package sync_pwm_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_PERIOD  = 2'd0;
    localparam logic [ADDR_W-1:0] A_COMPARE = 2'd1;
    localparam logic [ADDR_W-1:0] A_PHASE   = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL    = 2'd3;

    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        SO_TERMINAL = 2'd0,
        SO_PASS     = 2'd1,
        SO_OFF      = 2'd2,
        SO_OFF_ALT  = 2'd3
    } so_sel_e;

    // Packed so that the low control bits map straight onto the write data.
    typedef struct packed {
        so_sel_e so_sel;   // bits 4:3
        logic    sync_en;  // bit 2
        logic    invert;   // bit 1
        logic    run;      // bit 0
    } ctrl_t;
endpackage

// File: rtl/pwm_cfg_regs.sv
// Configuration storage: period, compare, phase and control word.
// A write is stored at the clock edge and is used from the next cycle on.
// Assumes wr_addr and wr_data are stable around the clock edge.
module pwm_cfg_regs
    import sync_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  compare,
    output logic [CNT_W-1:0]  phase,
    output ctrl_t             ctrl
);

    // Store a write in the register that the address selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period  <= '0;
            compare <= '0;
            phase   <= '0;
            ctrl    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_PERIOD:  period  <= wr_data;
                A_COMPARE: compare <= wr_data;
                A_PHASE:   phase   <= wr_data;
                A_CTRL:    ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:   ;
            endcase
        end
    end

    // R2: a control write lands as given on the following edge.
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_CTRL |=> ctrl == $past(wr_data[CTRL_W-1:0]));

    // R2: with no write strobe the period holds its value.
    p_period_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(period));

endmodule

// File: rtl/pwm_counter.sv
// Time base: steps up while running, wraps after period-1, and loads the
// phase value on a sync load. The sync load wins over stepping and also
// works while stopped. 'last' flags the final count of each repeat.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_load,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] phase,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] cnt_plus;

    // Compare count+1 against the period in a wider width so 0 and 1 are safe.
    always_comb begin
        cnt_plus = {1'b0, cnt} + EXT_W'(1);
        last     = cnt_plus >= {1'b0, period};
    end

    // Advance, wrap, hold or load the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sync_load) begin
            cnt <= phase;
        end else if (run) begin
            cnt <= last ? '0 : cnt_plus[CNT_W-1:0];
        end
    end

    // R7: a sync load places the phase value in the counter.
    p_sync_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_load |=> cnt == $past(phase));

    // R6: a stopped counter without a load keeps its value.
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !sync_load |=> $stable(cnt));

    // R3: the final count returns to zero.
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && !sync_load && last |=> cnt == '0);

    // R3: any other count moves up by one.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && !sync_load && !last |=> cnt == $past(cnt) + CNT_W'(1));

endmodule

// File: rtl/pwm_out_stage.sv
// Output logic: active window from the compare value, polarity, and the
// sync-output selector (terminal pulse, pass-through or off).
// Assumes cnt and the configuration come from registers.
module pwm_out_stage
    import sync_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] compare,
    input  logic             last,
    input  ctrl_t            ctrl,
    input  logic             sync_in,
    output logic             pwm_o,
    output logic             sync_out
);

    logic active;

    // Active window and polarity.
    always_comb begin
        active = cnt < compare;
        pwm_o  = active ^ ctrl.invert;
    end

    // Pick the sync output source.
    always_comb begin
        unique case (ctrl.so_sel)
            SO_TERMINAL: sync_out = ctrl.run & last;
            SO_PASS:     sync_out = sync_in;
            default:     sync_out = 1'b0;
        endcase
    end

    // R9: select 2 or 3 keeps sync_out low.
    p_sync_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.so_sel[1] |-> !sync_out);

    // R9: pass-through follows the input in the same cycle.
    p_sync_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.so_sel == SO_PASS |-> sync_out == sync_in);

    // R4: a zero compare keeps the output at its inactive level.
    p_cmp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        compare == '0 |-> pwm_o == ctrl.invert);

    // R10: no terminal pulse while stopped.
    p_no_pulse_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.so_sel == SO_TERMINAL && !ctrl.run |-> !sync_out);

endmodule

// File: rtl/sync_pwm_timer.sv
// Top of one synchronizable PWM timer channel. It ties the configuration
// registers, the counter and the output stage together. Channels chain
// sync_out to sync_in. Assumes sync_in comes from the same clock domain.
module sync_pwm_timer
    import sync_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [sync_pwm_pkg::ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    input  logic                        sync_in,
    output logic                        sync_out,
    output logic                        pwm_o
);

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] compare;
    logic [CNT_W-1:0] phase;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cnt;
    logic             last;
    logic             sync_load;

    // A sync pulse acts only when the sync input is enabled.
    always_comb sync_load = sync_in & ctrl.sync_en;

    pwm_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .period  (period),
        .compare (compare),
        .phase   (phase),
        .ctrl    (ctrl)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl.run),
        .sync_load (sync_load),
        .period    (period),
        .phase     (phase),
        .cnt       (cnt),
        .last      (last)
    );

    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .compare  (compare),
        .last     (last),
        .ctrl     (ctrl),
        .sync_in  (sync_in),
        .pwm_o    (pwm_o),
        .sync_out (sync_out)
    );

    // R10: a terminal pulse lasts one cycle when nothing disturbs the count.
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.so_sel == SO_TERMINAL && sync_out && period >= CNT_W'(2)
        && !sync_load && !wr_en |=> !sync_out);

    // R8: with the sync input disabled, a stopped counter ignores sync_in.
    p_sync_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.sync_en && !ctrl.run |=> $stable(cnt));

    // R1: the first cycle after reset has a zero count and a quiet output.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> cnt == '0 && ctrl == '0 && !pwm_o);

endmodule

// File: tb/tb_sync_pwm_timer.sv
`timescale 1ns/100ps
module tb_sync_pwm_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         sync_in = 1'b0;
    logic         sync_out;
    logic         pwm_o;

    always #2.5 clk = ~clk;

    sync_pwm_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .sync_out(sync_out), .pwm_o(pwm_o)
    );

    typedef struct {
        logic  pwm;
        logic  so;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // Reference model state, kept from the requirements.
    int m_cnt = 0, m_per = 0, m_cmp = 0, m_ph = 0, m_sel = 0;
    bit m_run = 0, m_inv = 0, m_sen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; push expected outputs for this cycle.
    task automatic cycle(input bit we, input int addr, input int data,
                         input bit si, input string req);
        exp_t e;
        bit   lst;
        @(negedge clk);
        wr_en = we; wr_addr = 2'(addr); wr_data = W'(data); sync_in = si;
        lst   = (m_cnt + 1) >= m_per;
        e.pwm = (m_cnt < m_cmp) ^ m_inv;
        e.so  = (m_sel == 0) ? (m_run && lst) : (m_sel == 1) ? si : 1'b0;
        e.req = req;
        q.push_back(e);
        if (si && m_sen) m_cnt = m_ph;
        else if (m_run) m_cnt = lst ? 0 : m_cnt + 1;
        if (we) begin
            case (addr)
                0: m_per = data;
                1: m_cmp = data;
                2: m_ph  = data;
                default: begin
                    m_run = data[0]; m_inv = data[1]; m_sen = data[2];
                    m_sel = (data >> 3) & 3;
                end
            endcase
        end
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, req);
    endtask

    function automatic int ctrlw(bit run, bit inv, bit sen, int sel);
        return (sel << 3) | (int'(sen) << 2) | (int'(inv) << 1) | int'(run);
    endfunction

    // Monitor: compare the design outputs with queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(pwm_o === e.pwm, e.req, "pwm_o", int'(pwm_o), int'(e.pwm));
                check(sync_out === e.so, e.req, "sync_out", int'(sync_out), int'(e.so));
            end
        end
    end

    // Measure pulse spacing and active cycles over n cycles.
    task automatic measure(input int n, input string req, output int gap, output int hi);
        int lastp = -1;
        gap = -1; hi = 0;
        for (int i = 0; i < n; i++) begin
            cycle(0, 0, 0, 0, req);
            #2;
            if (pwm_o) hi++;
            if (sync_out) begin
                if (lastp >= 0) gap = i - lastp;
                lastp = i;
            end
        end
    endtask

    initial begin
        int gap, hi;
        // R1: reset.
        repeat (3) @(negedge clk);
        #2;
        check(pwm_o === 1'b0 && sync_out === 1'b0, "R1", "outputs in reset",
              int'({pwm_o, sync_out}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(4, "R1");

        // R2, R3, R4, R10: period 10, compare 3, running.
        cycle(1, 0, 10, 0, "R2");
        cycle(1, 1, 3, 0, "R2");
        cycle(1, 3, ctrlw(1, 0, 0, 0), 0, "R2");
        measure(20, "R3", gap, hi);
        check(gap == 10, "R10", "pulse spacing period 10", gap, 10);
        check(hi == 6, "R4", "active cycles over two repeats", hi, 6);

        // R3: period 5 gives twice the frequency.
        cycle(1, 0, 5, 0, "R3");
        idle(5, "R3");
        measure(15, "R3", gap, hi);
        check(gap == 5, "R3", "pulse spacing period 5", gap, 5);

        // R5: inverted polarity.
        cycle(1, 3, ctrlw(1, 1, 0, 0), 0, "R5");
        idle(12, "R5");

        // R6: stop freezes the output.
        cycle(1, 3, ctrlw(0, 0, 0, 0), 0, "R6");
        idle(8, "R6");

        // R8: sync ignored while disabled (stopped and running).
        cycle(1, 2, 4, 0, "R8");
        cycle(0, 0, 0, 1, "R8");
        idle(3, "R8");
        cycle(1, 3, ctrlw(1, 0, 0, 0), 0, "R8");
        cycle(0, 0, 0, 1, "R8");
        idle(6, "R8");

        // R7: sync loads phase while running and while stopped.
        cycle(1, 3, ctrlw(1, 0, 1, 0), 0, "R7");
        idle(2, "R7");
        cycle(0, 0, 0, 1, "R7");
        idle(6, "R7");
        cycle(1, 3, ctrlw(0, 0, 1, 0), 0, "R7");
        cycle(1, 2, 1, 0, "R7");
        cycle(0, 0, 0, 1, "R7");
        idle(4, "R7");

        // R4: compare 0 and compare above the period.
        cycle(1, 3, ctrlw(1, 0, 0, 0), 0, "R4");
        cycle(1, 1, 0, 0, "R4");
        idle(8, "R4");
        cycle(1, 1, 15, 0, "R4");
        idle(8, "R4");

        // R9: pass-through and disabled sync output.
        cycle(1, 3, ctrlw(1, 0, 0, 1), 0, "R9");
        for (int i = 0; i < 6; i++) cycle(0, 0, 0, bit'(i % 2), "R9");
        cycle(1, 3, ctrlw(1, 0, 0, 2), 0, "R9");
        for (int i = 0; i < 6; i++) cycle(0, 0, 0, bit'(i % 2), "R9");
        cycle(1, 3, ctrlw(1, 0, 0, 3), 0, "R9");
        for (int i = 0; i < 6; i++) cycle(0, 0, 0, 1, "R9");

        // R3: period 1 holds the counter at zero.
        cycle(1, 3, ctrlw(1, 0, 0, 0), 0, "R3");
        cycle(1, 1, 1, 0, "R3");
        cycle(1, 0, 1, 0, "R3");
        idle(6, "R3");

        @(negedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule